// File: doc/BRIEF.md
# Synchronous Burst Cache Data SRAM

This block is a clocked static RAM meant to hold the data lines of a secondary cache sitting on a processor bus. Every input except the output enable is taken in on the rising clock edge. A new access begins when one of two address strobes is raised. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, as the write enable selects. A burst can then step through the rest of a four-word cache line. An internal 2-bit counter does the stepping, and it moves only on edges where the advance input is high. The counter value is XORed into the two low address bits. This gives the interleaved line order that processors use, and the upper address bits stay fixed for the whole burst.

Writes complete on the clock edge itself, so no external write pulse is needed. Read data is registered: it appears just after the edge that captured the address and stays until the next access. The output enable is the only control that is not registered. It gates the read data combinationally, and the `rd_valid` flag stands in for the high-impedance state of a real pad.

The data path has no back-pressure. A read result is presented for exactly one cycle, and the consumer must take it while `rd_valid` is high. The default depth is small for elaboration. Setting `ADDR_W` = 15 and `DATA_W` = 9 gives a 32,768 x 9 array.

Top module: `burst_cache_sram`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits. A word written at an address is returned unchanged by any later read of that address.
- R2: Inputs are sampled on the rising clock edge. The data for a read whose address is taken at edge N is presented right after edge N and held until edge N+1. A cycle that performs no read leaves `rd_valid` low after its edge.
- R3: If `cpu_stb` is high together with `chip_en`, the block loads `addr_in` as the burst base, clears the counter and reads that address. `wr_en` is ignored in that cycle.
- R4: If `ctl_stb` is high with `chip_en` and `cpu_stb` is low, the block loads `addr_in` as the burst base and clears the counter. It then writes `wdata_in` when `wr_en` is high, and reads otherwise.
- R5: When both strobes are high with `chip_en`, `cpu_stb` wins and the cycle is a read, whatever `wr_en` is.
- R6: On a cycle with no strobe and `adv` high, the counter steps by one and wraps from 3 back to 0. The accessed address is then {base[ADDR_W-1:2], base[1:0] XOR count}. The cycle reads, or writes if `wr_en` is high.
- R7: On a cycle with no strobe and `adv` low, the counter and base are held and the current burst address is accessed again, read or write per `wr_en`.
- R8: A strobe with `chip_en` low is ignored: there is no access, and neither the base nor the counter changes. A later advance continues the earlier burst.
- R9: `rd_valid` is high only while `out_en` is high and the last edge performed a read. `out_en` acts without a clock. While `rd_valid` is low, `rd_data` reads as all zeros.
- R10: After reset no burst is loaded. Cycles without an accepted strobe make no access, and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | ADDR_W | External word address |
| wdata_in | input | DATA_W | Write data |
| chip_en | input | 1 | Chip enable, looked at only on strobe cycles |
| wr_en | input | 1 | Write enable (high = write) |
| cpu_stb | input | 1 | Processor-side burst start (always a read) |
| ctl_stb | input | 1 | Controller-side burst start |
| adv | input | 1 | Advance the burst counter |
| out_en | input | 1 | Asynchronous output enable |
| rd_data | output | DATA_W | Read data, zero when not valid |
| rd_valid | output | 1 | Read data is being driven |

## Verification
The hardest state to reach from the ports is a burst that has been partly advanced and is then hit by a strobe that is ignored because `chip_en` is low, after which the burst has to resume at the right interleaved slot. The bench first writes a distinct computed pattern into every word. It then starts a burst from every possible base address, stepping past the wrap with a hold cycle in between. On selected bursts it inserts an ignored strobe that carries a different address and a high write enable, then advances again and compares each word with the arithmetic XOR order.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/bsr_seq.sv
`timescale 1ns/1ps
module bsr_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_stb,
  input  logic              ctl_stb,
  input  logic              chip_en,
  input  logic              wr_en,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr_in,
  output acc_kind_e         acc_kind,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam int UP_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              sel_q, sel_d;
  logic              any_stb, take;

  assign any_stb = cpu_stb | ctl_stb;
  assign take    = any_stb & chip_en;

  always_comb begin
    base_d   = base_q;
    cnt_d    = cnt_q;
    sel_d    = sel_q;
    acc_kind = ACC_NONE;
    acc_addr = base_q;
    if (take) begin
      base_d   = addr_in;
      cnt_d    = 2'd0;
      sel_d    = 1'b1;
      acc_addr = addr_in;
      acc_kind = (cpu_stb || !wr_en) ? ACC_READ : ACC_WRITE;
    end else if (!any_stb) begin
      if (adv) cnt_d = cnt_q + 2'd1;
      acc_addr = {base_q[ADDR_W-1 -: UP_W], base_q[1:0] ^ cnt_d};
      if (sel_q) acc_kind = wr_en ? ACC_WRITE : ACC_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      sel_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
    end
  end

  AST_LOAD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cnt_q == 2'd0) && (base_q == $past(addr_in))); // R4
  AST_ADVANCE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_stb && adv) |=> cnt_q == $past(cnt_q) + 2'd1); // R6
  AST_HOLD_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_stb && !adv) |=> $stable(cnt_q) && $stable(base_q)); // R7
  AST_IGNORED_STROBE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stb && !chip_en) |=> $stable(cnt_q) && $stable(base_q)); // R8
  AST_NO_ACCESS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && (any_stb || !sel_q)) |-> acc_kind == ACC_NONE); // R10
endmodule

// File: rtl/bsr_array.sv
`timescale 1ns/1ps
module bsr_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rword
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rword <= mem[addr];
  end

  AST_ONE_ACCESS: assert property (@(posedge clk)
    !(we && re)); // R1
endmodule

// File: rtl/bsr_out_stage.sv
`timescale 1ns/1ps
module bsr_out_stage #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] rword,
  input  logic              out_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= rd_fire;
  end

  assign rd_valid = out_en & hit_q;
  assign rd_data  = rd_valid ? rword : '0;

  AST_VALID_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_fire)); // R2
  AST_OE_LOW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (!rd_valid && rd_data == '0)); // R9
endmodule

// File: rtl/burst_cache_sram.sv
`timescale 1ns/1ps
module burst_cache_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              chip_en,
  input  logic              wr_en,
  input  logic              cpu_stb,
  input  logic              ctl_stb,
  input  logic              adv,
  input  logic              out_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  acc_kind_e         acc_kind;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] rword;
  logic              arr_we, arr_re;

  bsr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_stb  (cpu_stb),
    .ctl_stb  (ctl_stb),
    .chip_en  (chip_en),
    .wr_en    (wr_en),
    .adv      (adv),
    .addr_in  (addr_in),
    .acc_kind (acc_kind),
    .acc_addr (acc_addr)
  );

  assign arr_we = (acc_kind == ACC_WRITE);
  assign arr_re = (acc_kind == ACC_READ);

  AST_CPU_STROBE_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stb && chip_en) |-> (arr_re && !arr_we)); // R3 R5

  bsr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .re    (arr_re),
    .addr  (acc_addr),
    .wdata (wdata_in),
    .rword (rword)
  );

  bsr_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (arr_re),
    .rword    (rword),
    .out_en   (out_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: tb/burst_cache_sram_tb.sv
`timescale 1ns/1ps
module burst_cache_sram_tb;
  localparam int AW = 6;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] wdata_in = '0;
  logic          chip_en = 1'b0, wr_en = 1'b0, cpu_stb = 1'b0, ctl_stb = 1'b0;
  logic          adv = 1'b0, out_en = 1'b1;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [DW-1:0] m_mem [DEPTH];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = 2'd0;
  logic          m_sel = 1'b0;
  logic          m_hit = 1'b0;
  logic [DW-1:0] m_word = '0;

  always #2.5 clk = ~clk;

  burst_cache_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .wdata_in(wdata_in),
    .chip_en(chip_en), .wr_en(wr_en), .cpu_stb(cpu_stb), .ctl_stb(ctl_stb),
    .adv(adv), .out_en(out_en), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 37 + salt * 11 + 5) & ((1 << DW) - 1));
  endfunction

  task automatic check_out(input string tag);
    logic          ev;
    logic [DW-1:0] ed;
    ev = out_en & m_hit;
    ed = ev ? m_word : '0;
    checks++;
    if (rd_valid !== ev || rd_data !== ed) begin
      errors++;
      $display("FAIL %s: valid=%0b data=%0h expected valid=%0b data=%0h",
               tag, rd_valid, rd_data, ev, ed);
    end
  endtask

  task automatic step(input logic c_cpu, input logic c_ctl, input logic c_ce,
                      input logic c_we, input logic c_adv,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input string tag);
    logic          any, tk;
    int            kind; // 0 none, 1 read, 2 write
    logic [AW-1:0] aa;
    @(negedge clk);
    cpu_stb = c_cpu; ctl_stb = c_ctl; chip_en = c_ce; wr_en = c_we;
    adv = c_adv; addr_in = a; wdata_in = d;
    @(posedge clk);
    any  = c_cpu | c_ctl;
    tk   = any & c_ce;
    kind = 0;
    aa   = m_base;
    if (tk) begin
      m_base = a; m_cnt = 2'd0; m_sel = 1'b1; aa = a;
      kind = (c_cpu || !c_we) ? 1 : 2;
    end else if (!any) begin
      if (c_adv) m_cnt = m_cnt + 2'd1;
      aa = {m_base[AW-1:2], m_base[1:0] ^ m_cnt};
      if (m_sel) kind = c_we ? 2 : 1;
    end
    if (kind == 2) m_mem[aa] = d;
    if (kind == 1) m_word = m_mem[aa];
    m_hit = (kind == 1);
    #1;
    check_out(tag);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check_out("R10 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    // R10: no burst loaded, continuation cycles make no access
    step(0, 0, 1, 0, 1, '0, '0, "R10 idle advance");
    step(0, 0, 1, 0, 0, '0, '0, "R10 idle hold");

    // R1 R4: controller strobe writes every word
    for (int a = 0; a < DEPTH; a++)
      step(0, 1, 1, 1, 0, AW'(a), pat(a, 0), "R4 ctl write sweep");

    // R3 R1 R2: processor strobe reads every word, wr_en ignored
    for (int a = 0; a < DEPTH; a++)
      step(1, 0, 1, 1, 0, AW'(a), ~pat(a, 0), "R3 cpu read sweep ignores write");

    // R6 R7: a burst from every base, wrapping, with a hold in between
    for (int a = 0; a < DEPTH; a++) begin
      step(0, 1, 1, 0, 0, AW'(a), '0, "R4 ctl read start");
      step(0, 0, 1, 0, 1, '0, '0, "R6 advance 1");
      step(0, 0, 1, 0, 1, '0, '0, "R6 advance 2");
      step(0, 0, 1, 0, 0, '0, '0, "R7 hold address");
      step(0, 0, 1, 0, 1, '0, '0, "R6 advance 3");
      step(0, 0, 1, 0, 1, '0, '0, "R6 wrap to base");
      step(0, 0, 1, 0, 1, '0, '0, "R6 after wrap");
    end

    // R6: burst writes, then read the line back in burst order
    for (int a = 1; a < DEPTH; a += 5) begin
      step(0, 1, 1, 1, 0, AW'(a), pat(a, 3), "R4 ctl write start");
      for (int k = 1; k < 4; k++)
        step(0, 0, 1, 1, 1, '0, pat(a + k, 3), "R6 burst write");
      step(0, 0, 1, 1, 0, '0, pat(a, 4), "R7 rewrite held address");
      step(1, 0, 1, 0, 0, AW'(a), '0, "R3 cpu read line");
      for (int k = 1; k < 5; k++)
        step(0, 0, 1, 0, 1, '0, '0, "R6 burst read back");
    end

    // R5: both strobes with write enable: read wins
    for (int a = 0; a < DEPTH; a += 7) begin
      step(1, 1, 1, 1, 0, AW'(a), pat(a, 9), "R5 both strobes read");
      step(0, 1, 1, 0, 0, AW'(a), '0, "R5 memory unchanged");
    end

    // R8: ignored strobes mid-burst
    for (int a = 0; a < DEPTH; a += 9) begin
      step(0, 1, 1, 0, 0, AW'(a), '0, "R8 burst start");
      step(0, 0, 1, 0, 1, '0, '0, "R8 advance before ignore");
      step(0, 1, 0, 1, 0, AW'(a ^ 6'h2a), pat(a, 13), "R8 ctl strobe ignored");
      step(1, 0, 0, 1, 1, AW'(a ^ 6'h15), pat(a, 14), "R8 cpu strobe ignored");
      step(0, 0, 1, 0, 1, '0, '0, "R8 burst continues");
      step(0, 1, 1, 0, 0, AW'(a ^ 6'h2a), '0, "R8 no write happened");
    end

    // R9: asynchronous output enable
    step(1, 0, 1, 0, 0, AW'(12), '0, "R9 read before gating");
    @(negedge clk);
    out_en = 1'b0;
    #0.5;
    check_out("R9 oe low mid-cycle");
    out_en = 1'b1;
    #0.5;
    check_out("R9 oe high again");
    out_en = 1'b0;
    step(1, 0, 1, 0, 0, AW'(13), '0, "R9 read with oe low");
    out_en = 1'b1;
    #0.2;
    check_out("R9 oe restores data");
    step(0, 1, 1, 1, 0, AW'(13), pat(13, 20), "R2 write clears valid");
    step(0, 0, 1, 0, 0, '0, '0, "R2 read after write");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule